// File: doc/BRIEF.md
# DRAM User-Port Single-Transaction Sequencer

This block connects a simple CPU load/store port to the user-side command and data port of an external DRAM controller. It takes one read or one write at a time, of 1, 2 or 4 bytes. It converts the byte address into the controller's 16-bit unit address. A write is placed into the correct byte lanes of a 128-bit word, with a byte mask, so a partial write never needs a read-modify-write. A read picks the addressed bytes out of the 128-bit word that comes back.

No request is taken until the controller reports that calibration has finished. A small reset sequencer on the reference clock holds the controller reset and the core reset for the same number of cycles, then releases both together. The transaction logic runs on the user clock that the controller supplies, at a quarter of the memory interface rate.

Top module: `ddr_user_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `appEn`, `appWdfWren`, `appWdfEnd` and `rspValid` are low.
- R2: While `calibDone` is low, `reqReady` is low and no request is accepted, even when `reqValid` is held high.
- R3: `appAddr` is the aligned byte address shifted right by one bit, which is the controller's 16-bit unit address.
- R4: In the first cycle after a write is accepted, `appEn`, `appWdfWren` and `appWdfEnd` are all high together, and `appCmd` is 3'b000 (write).
- R5: `appEn`, `appCmd` and `appAddr` stay unchanged until a cycle in which `appRdy` is high, and `appEn` is low in the cycle after that. The write strobes and the write data stay unchanged until a cycle in which `appWdfRdy` is high, and are low in the cycle after that.
- R6: Byte lane k of the 128-bit bus holds bits 8k+7..8k. The offset is the low four bits of the aligned address. Request data byte i goes to lane offset+i. All other lanes carry zero. A mask bit of 1 marks a lane that is not written.
- R7: A read issues `appCmd` 3'b001 with the write strobes low. It then waits for `appRdDataValid`. In the next cycle `rspValid` pulses with the addressed bytes, lane offset+i giving result byte i, zero-extended to 32 bits.
- R8: A write pulses `rspValid` for one cycle, in the cycle after both the command and the data have been accepted.
- R9: Only one request is outstanding. `reqReady` is low from acceptance through the `rspValid` cycle.
- R10: `reqSize` encodes 0 as 1 byte, 1 as 2 bytes and 2 as 4 bytes. The code 3 is treated as 4 bytes. Address bits below the access size are ignored.
- R11: After `porN` goes high, `memRst` is high and `coreRstN` is low for exactly RST_HOLD reference-clock cycles. Both then release in the same cycle, and `coreRstN` always equals the inverse of `memRst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock from the DRAM controller |
| rst | input | 1 | Synchronous reset, active high, in the user clock domain |
| calibDone | input | 1 | Controller calibration complete |
| reqValid | input | 1 | CPU request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqSize | input | 2 | Access size code (R10) |
| reqWdata | input | 32 | Write data, byte 0 in bits 7..0 |
| reqReady | output | 1 | Request accepted when high with reqValid |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | 32 | Read result, valid with rspValid on reads |
| appAddr | output | ADDR_W-1 | Controller address in 16-bit units |
| appCmd | output | 3 | Controller command: 000 write, 001 read |
| appEn | output | 1 | Command enable |
| appRdy | input | 1 | Controller accepts the command |
| appWdfData | output | DATA_W | Write data word |
| appWdfMask | output | DATA_W/8 | Byte mask, 1 = lane not written |
| appWdfWren | output | 1 | Write data valid |
| appWdfEnd | output | 1 | Last write data beat |
| appWdfRdy | input | 1 | Controller accepts write data |
| appRdData | input | DATA_W | Read data word |
| appRdDataValid | input | 1 | Read data valid strobe |
| refClk | input | 1 | Reference clock for reset sequencing |
| porN | input | 1 | Power-on reset, active low, in the refClk domain |
| memRst | output | 1 | Controller reset, active high |
| coreRstN | output | 1 | Core reset, active low |

## Verification
A wrong phase in the sequencer shows on the next user-clock edge. It appears as an enable that stays high after `appRdy`, as write strobes that drop before `appWdfRdy`, as `rspValid` in the wrong cycle, or as `reqReady` rising while a transaction is still open. A wrong lane offset or size decode shows at once on `appWdfData` and `appWdfMask` in the first command cycle, and on `rspRdata` in the response cycle. A reset counter that loads or steps wrongly shows as a release edge off by one or more reference cycles.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_RDWAIT, ST_DONE} seqState_t;

  typedef struct packed {
    logic load;     // latch a new request
    logic capture;  // latch the returned read word
  } dpCtl_t;

  localparam logic [2:0] CMD_WRITE = 3'b000;
  localparam logic [2:0] CMD_READ  = 3'b001;
endpackage

// File: rtl/dram_seq_rstgen.sv
module dram_seq_rstgen #(
  parameter int RST_HOLD = 2000
) (
  input  logic refClk,
  input  logic porN,
  output logic memRst,
  output logic coreRstN
);
  localparam int CNT_W = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge refClk) begin
    if (!porN) holdCnt <= CNT_W'(RST_HOLD);
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign memRst   = (holdCnt != '0);
  assign coreRstN = (holdCnt == '0);

  // R11: the hold counter steps down by one per reference cycle
  a_r11_count_down: assert property (@(posedge refClk) disable iff (!porN)
    (holdCnt != '0) |=> (holdCnt == $past(holdCnt) - 1'b1));
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       calibDone,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       rspValid,
  output logic [2:0] appCmd,
  output logic       appEn,
  input  logic       appRdy,
  output logic       appWdfWren,
  output logic       appWdfEnd,
  input  logic       appWdfRdy,
  input  logic       appRdDataValid,
  output dpCtl_t     dpCtl
);
  seqState_t state;
  logic isWrite, cmdDone, dataDone;
  logic cmdOk, dataOk;

  assign reqReady   = (state == ST_IDLE) && calibDone;
  assign appEn      = (state == ST_CMD) && !cmdDone;
  assign appWdfWren = (state == ST_CMD) && isWrite && !dataDone;
  assign appWdfEnd  = appWdfWren;
  assign appCmd     = isWrite ? CMD_WRITE : CMD_READ;
  assign rspValid   = (state == ST_DONE);

  assign cmdOk  = cmdDone || (appEn && appRdy);
  assign dataOk = !isWrite || dataDone || (appWdfWren && appWdfRdy);

  always_comb begin
    dpCtl.load    = reqReady && reqValid;
    dpCtl.capture = (state == ST_RDWAIT) && appRdDataValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      isWrite  <= 1'b0;
      cmdDone  <= 1'b0;
      dataDone <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (dpCtl.load) begin
          isWrite  <= reqWrite;
          cmdDone  <= 1'b0;
          dataDone <= 1'b0;
          state    <= ST_CMD;
        end
        ST_CMD: begin
          cmdDone  <= cmdOk;
          dataDone <= dataOk;
          if (cmdOk && dataOk) state <= isWrite ? ST_DONE : ST_RDWAIT;
        end
        ST_RDWAIT: if (appRdDataValid) state <= ST_DONE;
        ST_DONE:   state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R4: write data strobes open together with a write command
  a_r4_same_cycle: assert property (@(posedge clk) disable iff (rst)
    $rose(appWdfWren) |-> (appEn && appCmd == CMD_WRITE));
  // R5: command held while the controller is not ready
  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    (appEn && !appRdy) |=> (appEn && $stable(appCmd)));
  // R5: write data strobe held while the data port is not ready
  a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
    (appWdfWren && !appWdfRdy) |=> appWdfWren);
  // R7: a read completes in the cycle after the data strobe
  a_r7_read_resp: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDWAIT && appRdDataValid) |=> rspValid);
  // R9: nothing new is taken during the completion cycle
  a_r9_single: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !reqReady);
endmodule

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 128
) (
  input  logic                  clk,
  input  logic                  rst,
  input  dpCtl_t                dpCtl,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [1:0]            reqSize,
  input  logic [31:0]           reqWdata,
  input  logic [DATA_W-1:0]     appRdData,
  output logic [ADDR_W-2:0]     appAddr,
  output logic [DATA_W-1:0]     appWdfData,
  output logic [DATA_W/8-1:0]   appWdfMask,
  output logic [31:0]           rspRdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [1:0]        sizeM1, latchM1;
  logic [ADDR_W-1:0] latchAddr;
  logic [31:0]       latchWdata, keepNew, keepCur;
  logic [DATA_W-1:0] rdWord, rdShifted;
  logic [3:0]        enNew, enCur;
  logic [OFF_W-1:0]  off;

  always_comb begin
    unique case (reqSize)
      2'd0:    sizeM1 = 2'd0;
      2'd1:    sizeM1 = 2'd1;
      default: sizeM1 = 2'd3;
    endcase
  end

  assign enNew = (sizeM1 == 2'd0) ? 4'b0001 : (sizeM1 == 2'd1) ? 4'b0011 : 4'b1111;
  assign enCur = (latchM1 == 2'd0) ? 4'b0001 : (latchM1 == 2'd1) ? 4'b0011 : 4'b1111;

  for (genvar k = 0; k < 4; k++) begin : g_keep
    assign keepNew[k*8 +: 8] = {8{enNew[k]}};
    assign keepCur[k*8 +: 8] = {8{enCur[k]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latchAddr  <= '0;
      latchM1    <= '0;
      latchWdata <= '0;
      rdWord     <= '0;
    end else begin
      if (dpCtl.load) begin
        latchAddr  <= reqAddr & ~ADDR_W'(sizeM1);
        latchM1    <= sizeM1;
        latchWdata <= reqWdata & keepNew;
      end
      if (dpCtl.capture) rdWord <= appRdData;
    end
  end

  assign off        = latchAddr[OFF_W-1:0];
  assign appAddr    = latchAddr[ADDR_W-1:1];
  assign appWdfData = DATA_W'(latchWdata) << {off, 3'b000};
  assign appWdfMask = ~(LANES'(enCur) << off);
  assign rdShifted  = rdWord >> {off, 3'b000};
  assign rspRdata   = rdShifted[31:0] & keepCur;
endmodule

// File: rtl/ddr_user_seq.sv
module ddr_user_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 128,
  parameter int RST_HOLD = 2000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                calibDone,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqSize,
  input  logic [31:0]         reqWdata,
  output logic                reqReady,
  output logic                rspValid,
  output logic [31:0]         rspRdata,
  output logic [ADDR_W-2:0]   appAddr,
  output logic [2:0]          appCmd,
  output logic                appEn,
  input  logic                appRdy,
  output logic [DATA_W-1:0]   appWdfData,
  output logic [DATA_W/8-1:0] appWdfMask,
  output logic                appWdfWren,
  output logic                appWdfEnd,
  input  logic                appWdfRdy,
  input  logic [DATA_W-1:0]   appRdData,
  input  logic                appRdDataValid,
  input  logic                refClk,
  input  logic                porN,
  output logic                memRst,
  output logic                coreRstN
);
  dpCtl_t dpCtl;

  dram_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .calibDone(calibDone), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqReady(reqReady), .rspValid(rspValid),
    .appCmd(appCmd), .appEn(appEn), .appRdy(appRdy), .appWdfWren(appWdfWren),
    .appWdfEnd(appWdfEnd), .appWdfRdy(appWdfRdy),
    .appRdDataValid(appRdDataValid), .dpCtl(dpCtl)
  );

  dram_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .appRdData(appRdData), .appAddr(appAddr),
    .appWdfData(appWdfData), .appWdfMask(appWdfMask), .rspRdata(rspRdata)
  );

  dram_seq_rstgen #(.RST_HOLD(RST_HOLD)) u_rst (
    .refClk(refClk), .porN(porN), .memRst(memRst), .coreRstN(coreRstN)
  );

  // R6: a write opens exactly 1, 2 or 4 lanes of the mask
  a_r6_lane_count: assert property (@(posedge clk) disable iff (rst)
    appWdfWren |-> ($countones(~appWdfMask) == 1 || $countones(~appWdfMask) == 2 ||
                    $countones(~appWdfMask) == 4));
  // R5: write word and mask stay put while the data port stalls
  a_r5_wdata_stable: assert property (@(posedge clk) disable iff (rst)
    (appWdfWren && !appWdfRdy) |=> ($stable(appWdfData) && $stable(appWdfMask)));
endmodule

// File: tb/tb_ddr_user_seq.sv
module tb_ddr_user_seq;
  localparam int HOLD = 40;

  logic clk = 0, refClk = 0;
  always #10 clk = ~clk;
  always #10 refClk = ~refClk;

  logic rst = 1, calibDone = 0, reqValid = 0, reqWrite = 0, porN = 0;
  logic [27:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic appRdy = 1, appWdfRdy = 1, appRdDataValid = 0;
  logic [127:0] appRdData = '0;
  logic reqReady, rspValid, appEn, appWdfWren, appWdfEnd, memRst, coreRstN;
  logic [31:0] rspRdata;
  logic [26:0] appAddr;
  logic [2:0] appCmd;
  logic [127:0] appWdfData;
  logic [15:0] appWdfMask;

  ddr_user_seq #(.RST_HOLD(HOLD)) dut (.*);

  int checks = 0, errors = 0, wd = 0, cyc = 0;
  int rdyPer = 1, wdfPer = 1, rdLat = 0;
  int readsIssued = 0, readsServed = 0, waitCnt = 0;
  logic [127:0] rdWordSrc = '0;
  bit cmpOn = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nb(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  // behavioural reference model
  int mState = 0, mA = 0, mN = 1;
  bit mWr = 0, mC = 0, mD = 0;
  logic [31:0] mWd = '0;
  logic [127:0] mWord = '0;

  always @(posedge clk) begin
    if (rst) mState = 0;
    else case (mState)
      0: if (reqValid && calibDone) begin
        mWr = reqWrite; mN = nb(reqSize);
        mA = int'(reqAddr) & ~(mN - 1);
        mWd = reqWdata; mC = 0; mD = 0; mState = 1;
      end
      1: begin
        mC = mC || appRdy;
        mD = !mWr || mD || appWdfRdy;
        if (mC && mD) mState = mWr ? 3 : 2;
      end
      2: if (appRdDataValid) begin mWord = appRdData; mState = 3; end
      default: mState = 0;
    endcase
  end

  always @(negedge clk) begin
    if (appEn && appRdy && appCmd == 3'b001) readsIssued++;
    if (cmpOn) begin
      bit eReady, eEn, eWr, eRsp;
      logic [127:0] eData, eMask;
      logic [31:0] eRd;
      int off;
      eReady = (mState == 0) && calibDone;
      eEn = (mState == 1) && !mC;
      eWr = (mState == 1) && mWr && !mD;
      eRsp = (mState == 3);
      off = mA % 16;
      eData = '0; eMask = '1; eRd = '0;
      for (int i = 0; i < mN; i++) begin
        eData[(off+i)*8 +: 8] = mWd[i*8 +: 8];
        eMask[off+i] = 1'b0;
        eRd[i*8 +: 8] = mWord[(off+i)*8 +: 8];
      end
      chk(reqReady === eReady, rst ? "R1 R2 R9 reqReady" : "R2 R9 reqReady", 128'(reqReady), 128'(eReady));
      chk(appEn === eEn, rst ? "R1 R5 appEn" : "R5 appEn", 128'(appEn), 128'(eEn));
      chk(appWdfWren === eWr, "R1 R4 R5 appWdfWren", 128'(appWdfWren), 128'(eWr));
      chk(appWdfEnd === eWr, "R4 appWdfEnd", 128'(appWdfEnd), 128'(eWr));
      chk(rspValid === eRsp, "R1 R8 rspValid", 128'(rspValid), 128'(eRsp));
      if (eEn) begin
        chk(appCmd === (mWr ? 3'b000 : 3'b001), "R4 R7 appCmd", 128'(appCmd), 128'(mWr ? 0 : 1));
        chk(appAddr === 27'(mA >> 1), "R3 R10 appAddr", 128'(appAddr), 128'(mA >> 1));
      end
      if (eWr) begin
        chk(appWdfData === eData, "R6 R10 appWdfData", appWdfData, eData);
        chk(appWdfMask === eMask[15:0], "R6 R10 appWdfMask", 128'(appWdfMask), 128'(eMask[15:0]));
      end
      if (eRsp && !mWr)
        chk(rspRdata === eRd, "R7 R10 rspRdata", 128'(rspRdata), 128'(eRd));
    end
  end

  // controller responder
  initial forever begin
    @(posedge clk); #2;
    cyc++;
    appRdy = (cyc % rdyPer) == 0;
    appWdfRdy = (cyc % wdfPer) == 0;
    appRdDataValid = 0;
    if (readsIssued > readsServed) begin
      if (waitCnt >= rdLat) begin
        appRdDataValid = 1; appRdData = rdWordSrc; readsServed++; waitCnt = 0;
      end else waitCnt++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic doReq(input bit wr, input logic [27:0] a, input logic [1:0] s,
                       input logic [31:0] d);
    @(posedge clk); #2;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqSize = s; reqWdata = d;
    forever begin @(negedge clk); if (reqReady) break; end
    @(posedge clk); #2; reqValid = 0;
    forever begin @(negedge clk); if (rspValid) break; end
  endtask

  initial begin
    int highCnt = 0;
    repeat (2) @(posedge clk);
    #2 cmpOn = 1;
    repeat (2) @(posedge refClk);
    #2 porN = 1;
    // R11: reset hold length and joint release
    for (int i = 0; i < HOLD + 10; i++) begin
      @(negedge clk);
      if (memRst) highCnt++;
      chk(coreRstN === !memRst, "R11 coreRstN", 128'(coreRstN), 128'(!memRst));
    end
    chk(highCnt == HOLD, "R11 hold length", 128'(highCnt), 128'(HOLD));

    @(posedge clk); #2 rst = 0;
    // R2: request waits for calibration
    reqValid = 1; reqWrite = 1; reqAddr = 28'h10; reqSize = 2'd2; reqWdata = 32'h11223344;
    repeat (8) @(posedge clk);
    #2 calibDone = 1;
    doReq(1, 28'h10, 2'd2, 32'h11223344);

    // writes, fast controller
    doReq(1, 28'h0000000, 2'd2, 32'hDEADBEEF);
    doReq(1, 28'h0000005, 2'd0, 32'h000000A7);
    doReq(1, 28'h000000A, 2'd1, 32'hFFFF5A3C);
    doReq(1, 28'h123456F, 2'd0, 32'h99999981);
    // R5: slow command port
    rdyPer = 3;
    doReq(1, 28'h000000C, 2'd2, 32'hCAFEF00D);
    // R5: slow data port
    rdyPer = 1; wdfPer = 4;
    doReq(1, 28'h0000027, 2'd2, 32'h01020304);
    // R10: size code 3 and misaligned halfword
    rdyPer = 2; wdfPer = 1;
    doReq(1, 28'h0000039, 2'd3, 32'hA1B2C3D4);
    doReq(1, 28'h0000043, 2'd1, 32'h0000BEEF);

    // reads
    rdyPer = 1; wdfPer = 1;
    rdWordSrc = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;
    rdLat = 0;
    doReq(0, 28'h0000100, 2'd2, '0);
    rdLat = 3;
    doReq(0, 28'h000010F, 2'd0, '0);
    rdWordSrc = 128'h0F0E0D0C_0B0A0908_07060504_03020100;
    rdyPer = 3;
    doReq(0, 28'h0000006, 2'd1, '0);
    doReq(0, 28'h000000C, 2'd2, '0);
    rdyPer = 1; rdLat = 1;
    doReq(0, 28'h0000009, 2'd3, '0);
    doReq(0, 28'h0000007, 2'd1, '0);

    // R2: calibration drop blocks new requests
    @(posedge clk); #2 calibDone = 0;
    reqValid = 1; reqWrite = 0; reqAddr = 28'h20; reqSize = 2'd0;
    repeat (5) @(posedge clk);
    #2 reqValid = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule